// File: doc/BRIEF.md
# Two-Channel Brightness Ramp Sequencer

The block drives the brightness codes of two LED current sinks, a main channel and a secondary channel. Each channel holds a 5-bit code that walks one step at a time toward a target code. Steps are spaced by a step period picked from four choices with a 2-bit rate field. A lookup turns each code into a level on a roughly exponential curve, given as a fraction of the sink's full-scale current. The targets, enables, unison select, feedback-mode select and rate field come from a register block. The outputs feed the analog sink drivers.

A ramp that is under way is never redirected by a new target. The channel first reaches the target it was heading for, then sets off toward the newer one. Clearing an enable is the exception: it turns the channel around at once, and the channel fades to zero on the same step cadence. In unison mode the secondary channel copies the main channel's target and enable. In feedback mode the secondary sink is switched off outright, and only the main channel ramps. Step periods are counted in system clock cycles and set by parameters.

Top module: `brt_ramp_ctrl`

## Requirements
- R1: A channel's code changes by exactly one per step. The first step of a ramp that starts from rest lands on the first clock edge that sees the new goal. Each later step lands one step period after the one before it.
- R2: The step period in clock cycles follows rate_i: 2'b00 gives PER_RATE0, 2'b10 gives PER_RATE2 (the 13 ms setting), 2'b01 gives PER_RATE1 (the 26 ms setting) and 2'b11 gives PER_RATE3 (the 52 ms setting).
- R3: A full-scale move from code 31 to code 0 takes 31 steps. The first step is immediate, so code 0 is reached 30 step periods after that first step.
- R4: The level output is in units of 1/1600 of full-scale current. Codes 0, 16, 24, 30 and 31 give 0, 140, 500, 1400 and 1600. The level rises strictly with every increase of the code.
- R5: Setting a channel's enable ramps that channel up from code 0 toward its target.
- R6: Clearing an enable in the middle of a ramp reverses the channel toward 0 at the same step cadence. The old target is not reached, and the code never rises while the enable is low.
- R7: A target written during a ramp does not redirect it. The channel finishes the ramp to the previous goal, then starts toward the new target one cycle later.
- R8: When unison_i is 1, the secondary channel uses main_tgt_i and main_en_i. sub_tgt_i and sub_en_i have no effect.
- R9: While oled_i is 1, the secondary code is forced to 0 and its active flag to 0 on the next edge, and its inputs are ignored. The main channel ramps as usual. When oled_i is cleared, the secondary channel ramps up from 0.
- R10: A channel's active flag goes to 1 on the edge after its effective enable is seen high. It goes to 0 only on the edge where its code reaches 0 with the enable low.
- R11: Reset clears both codes, levels and active flags at once, with no fade.
- R12: When unison_i is 0, each channel follows its own target and enable, and a change on one channel leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous register-clearing reset |
| rate_i | input | 2 | Step period select |
| unison_i | input | 1 | Secondary channel follows the main target and enable |
| oled_i | input | 1 | Secondary sink switched off (voltage feedback use) |
| main_en_i | input | 1 | Main channel enable |
| main_tgt_i | input | 5 | Main channel target code |
| sub_en_i | input | 1 | Secondary channel enable |
| sub_tgt_i | input | 5 | Secondary channel target code |
| main_code_o | output | 5 | Main channel current code |
| main_level_o | output | 11 | Main channel level, 1/1600 of full scale |
| main_active_o | output | 1 | Main sink active |
| sub_code_o | output | 5 | Secondary channel current code |
| sub_level_o | output | 11 | Secondary channel level, 1/1600 of full scale |
| sub_active_o | output | 1 | Secondary sink active |

## Verification
The assertions check properties that must hold every cycle. The code never moves by more than one step, except when feedback mode forces it to zero. It never rises while its enable is low. An inactive sink always sits at code 0, and an enable always raises the active flag. Feedback mode always zeroes the secondary channel, and reset leaves both codes at zero. Other behaviour can only be shown by the bench's timed scenarios: the exact edge of each step under every rate setting, the deferral of a target written mid-ramp, the turn-around when an enable drops, the full-scale fade length, unison following and the level values.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int CODE_W  = 5;
    localparam int LEVEL_W = 11;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [LEVEL_W-1:0] level_t;

    // Level in units of 1/1600 of full-scale current (0.0625 % each).
    function automatic level_t level_of(input code_t c);
        level_t v;
        case (c)
            5'd0:  v = 11'd0;    5'd1:  v = 11'd2;
            5'd2:  v = 11'd10;   5'd3:  v = 11'd16;
            5'd4:  v = 11'd18;   5'd5:  v = 11'd21;
            5'd6:  v = 11'd27;   5'd7:  v = 11'd33;
            5'd8:  v = 11'd39;   5'd9:  v = 11'd45;
            5'd10: v = 11'd50;   5'd11: v = 11'd60;
            5'd12: v = 11'd70;   5'd13: v = 11'd84;
            5'd14: v = 11'd100;  5'd15: v = 11'd120;
            5'd16: v = 11'd140;  5'd17: v = 11'd160;
            5'd18: v = 11'd200;  5'd19: v = 11'd240;
            5'd20: v = 11'd270;  5'd21: v = 11'd300;
            5'd22: v = 11'd360;  5'd23: v = 11'd420;
            5'd24: v = 11'd500;  5'd25: v = 11'd600;
            5'd26: v = 11'd700;  5'd27: v = 11'd840;
            5'd28: v = 11'd980;  5'd29: v = 11'd1120;
            5'd30: v = 11'd1400;
            default: v = 11'd1600;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/brt_period_sel.sv
module brt_period_sel #(
    parameter int PER_RATE0 = 510,
    parameter int PER_RATE1 = 260000,
    parameter int PER_RATE2 = 130000,
    parameter int PER_RATE3 = 520000,
    parameter int CNT_W     = 20
) (
    input  logic [1:0]       rate_i,
    output logic [CNT_W-1:0] period_o
);

    always_comb begin
        case (rate_i)
            2'b00:   period_o = CNT_W'(PER_RATE0);
            2'b01:   period_o = CNT_W'(PER_RATE1);
            2'b10:   period_o = CNT_W'(PER_RATE2);
            default: period_o = CNT_W'(PER_RATE3);
        endcase
    end

endmodule

// File: rtl/brt_channel.sv
module brt_channel
    import brt_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             kill_i,
    input  code_t            target_i,
    input  logic [CNT_W-1:0] period_i,
    output code_t            code_o,
    output level_t           level_o,
    output logic             active_o
);

    typedef struct packed {
        code_t            code;
        code_t            goal;
        logic [CNT_W-1:0] cnt;
        logic             act;
    } chan_st_t;

    chan_st_t st_q, st_d;
    code_t    want;
    logic     at_rest;

    always_comb begin
        st_d    = st_q;
        want    = en_i ? target_i : '0;
        at_rest = (st_q.code == st_q.goal);

        if (!en_i) begin
            st_d.goal = '0;
        end else if (at_rest) begin
            st_d.goal = want;
        end

        if (kill_i) begin
            st_d = '0;
        end else begin
            if (st_q.code != st_d.goal) begin
                if (at_rest || (st_q.cnt == '0)) begin
                    st_d.code = (st_d.goal > st_q.code) ? st_q.code + 1'b1
                                                        : st_q.code - 1'b1;
                    st_d.cnt  = period_i - CNT_W'(1);
                end else begin
                    st_d.cnt  = st_q.cnt - CNT_W'(1);
                end
            end else begin
                st_d.cnt = '0;
            end
            st_d.act = en_i | (st_q.act & (st_d.code != '0));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o   = st_q.code;
    assign level_o  = level_of(st_q.code);
    assign active_o = st_q.act;

    assert_single_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !kill_i |=> (({1'b0, st_q.code} == {1'b0, $past(st_q.code)}) ||
                     ({1'b0, st_q.code} == {1'b0, $past(st_q.code)} + 6'd1) ||
                     ({1'b0, st_q.code} + 6'd1 == {1'b0, $past(st_q.code)})));

    assert_no_rise_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (st_q.code <= $past(st_q.code)));

    assert_idle_at_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_o |-> (code_o == '0));

    assert_enable_raises_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !kill_i) |=> active_o);

endmodule

// File: rtl/brt_ramp_ctrl.sv
module brt_ramp_ctrl
    import brt_pkg::*;
#(
    parameter int PER_RATE0 = 510,
    parameter int PER_RATE1 = 260000,
    parameter int PER_RATE2 = 130000,
    parameter int PER_RATE3 = 520000
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [1:0]   rate_i,
    input  logic         unison_i,
    input  logic         oled_i,
    input  logic         main_en_i,
    input  logic [4:0]   main_tgt_i,
    input  logic         sub_en_i,
    input  logic [4:0]   sub_tgt_i,
    output logic [4:0]   main_code_o,
    output logic [10:0]  main_level_o,
    output logic         main_active_o,
    output logic [4:0]   sub_code_o,
    output logic [10:0]  sub_level_o,
    output logic         sub_active_o
);

    localparam int NUM_CH = 2;
    localparam int MAX_A  = (PER_RATE0 > PER_RATE1) ? PER_RATE0 : PER_RATE1;
    localparam int MAX_B  = (PER_RATE2 > PER_RATE3) ? PER_RATE2 : PER_RATE3;
    localparam int MAX_P  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = (MAX_P > 1) ? $clog2(MAX_P + 1) : 1;

    logic [CNT_W-1:0] period;
    logic             ch_en   [NUM_CH];
    logic             ch_kill [NUM_CH];
    code_t            ch_tgt  [NUM_CH];
    code_t            ch_code [NUM_CH];
    level_t           ch_lvl  [NUM_CH];
    logic             ch_act  [NUM_CH];

    brt_period_sel #(
        .PER_RATE0 (PER_RATE0),
        .PER_RATE1 (PER_RATE1),
        .PER_RATE2 (PER_RATE2),
        .PER_RATE3 (PER_RATE3),
        .CNT_W     (CNT_W)
    ) u_period (
        .rate_i   (rate_i),
        .period_o (period)
    );

    // Channel 0 is main, channel 1 is secondary.
    always_comb begin
        ch_en[0]   = main_en_i;
        ch_tgt[0]  = main_tgt_i;
        ch_kill[0] = 1'b0;
        ch_en[1]   = !oled_i && (unison_i ? main_en_i : sub_en_i);
        ch_tgt[1]  = unison_i ? main_tgt_i : sub_tgt_i;
        ch_kill[1] = oled_i;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        brt_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (ch_en[g]),
            .kill_i   (ch_kill[g]),
            .target_i (ch_tgt[g]),
            .period_i (period),
            .code_o   (ch_code[g]),
            .level_o  (ch_lvl[g]),
            .active_o (ch_act[g])
        );
    end

    assign main_code_o   = ch_code[0];
    assign main_level_o  = ch_lvl[0];
    assign main_active_o = ch_act[0];
    assign sub_code_o    = ch_code[1];
    assign sub_level_o   = ch_lvl[1];
    assign sub_active_o  = ch_act[1];

    assert_feedback_kills_sub_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oled_i |=> (sub_code_o == 5'd0 && !sub_active_o));

    assert_reset_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (main_code_o == 5'd0 && sub_code_o == 5'd0));

endmodule

// File: tb/brt_ramp_ctrl_test.sv
module brt_ramp_ctrl_test;

    localparam int P0 = 3;   // rate 2'b00
    localparam int P1 = 9;   // rate 2'b01
    localparam int P2 = 6;   // rate 2'b10
    localparam int P3 = 12;  // rate 2'b11

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate = 2'b00;
    logic        unison = 1'b0, oled = 1'b0;
    logic        main_en = 1'b0, sub_en = 1'b0;
    logic [4:0]  main_tgt = '0, sub_tgt = '0;
    logic [4:0]  main_code, sub_code;
    logic [10:0] main_level, sub_level;
    logic        main_active, sub_active;

    always #4 clk = ~clk;

    brt_ramp_ctrl #(
        .PER_RATE0 (P0), .PER_RATE1 (P1), .PER_RATE2 (P2), .PER_RATE3 (P3)
    ) uut (
        .clk_i (clk), .rst_ni (rst_n), .rate_i (rate),
        .unison_i (unison), .oled_i (oled),
        .main_en_i (main_en), .main_tgt_i (main_tgt),
        .sub_en_i (sub_en), .sub_tgt_i (sub_tgt),
        .main_code_o (main_code), .main_level_o (main_level), .main_active_o (main_active),
        .sub_code_o (sub_code), .sub_level_o (sub_level), .sub_active_o (sub_active)
    );

    typedef struct {
        int    code;
        int    cyc;
        string req;
    } exp_t;

    exp_t  q_main[$];
    exp_t  q_sub[$];
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R11";
    int    prev_code[2] = '{0, 0};
    int    prev_lvl[2]  = '{0, 0};

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int ch, input int code, input int at, input string req);
        exp_t e;
        e.code = code; e.cyc = at; e.req = req;
        if (ch == 0) q_main.push_back(e);
        else         q_sub.push_back(e);
    endtask

    task automatic plan_ramp(input int ch, input int from, input int to, input int first,
                             input int per, input string req, output int last);
        int c = from;
        int t = first;
        last = first;
        while (c != to) begin
            c = (to > c) ? c + 1 : c - 1;
            push(ch, c, t, req);
            last = t;
            t += per;
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain(input string req);
        chk(q_main.size() == 0 && q_sub.size() == 0, req, "pending expected steps",
            q_main.size() + q_sub.size(), 0);
    endtask

    function automatic int ref_level(input int code);
        case (code)
            0:  return 0;
            16: return 140;
            24: return 500;
            30: return 1400;
            31: return 1600;
            default: return -1;
        endcase
    endfunction

    task automatic observe(input int ch, input int code, input int lvl);
        exp_t e;
        bit   empty;
        if (code != prev_code[ch]) begin
            empty = (ch == 0) ? (q_main.size() == 0) : (q_sub.size() == 0);
            if (empty) begin
                chk(1'b0, cur_req, $sformatf("unexpected change ch%0d cyc %0d", ch, cyc),
                    code, prev_code[ch]);
            end else begin
                if (ch == 0) e = q_main.pop_front();
                else         e = q_sub.pop_front();
                chk(code == e.code, e.req, $sformatf("code ch%0d", ch), code, e.code);
                chk(cyc == e.cyc, e.req, $sformatf("step cycle ch%0d", ch), cyc, e.cyc);
            end
            if (code - prev_code[ch] == 1 || prev_code[ch] - code == 1)
                chk(((code > prev_code[ch]) == (lvl > prev_lvl[ch])) && lvl != prev_lvl[ch],
                    "R4", "level order", lvl, prev_lvl[ch]);
            if (ref_level(code) >= 0)
                chk(lvl == ref_level(code), "R4", $sformatf("level of code %0d", code),
                    lvl, ref_level(code));
            prev_code[ch] = code;
            prev_lvl[ch]  = lvl;
        end
    endtask

    // Monitor: pops expected steps as the design produces them.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            observe(0, int'(main_code), int'(main_level));
            observe(1, int'(sub_code), int'(sub_level));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int last;
        int last2;

        repeat (3) @(negedge clk);
        chk(main_code == 0 && sub_code == 0, "R11", "codes in reset", main_code + sub_code, 0);
        chk(main_level == 0 && sub_level == 0, "R11", "levels in reset", main_level + sub_level, 0);
        chk(!main_active && !sub_active, "R11", "active in reset", main_active + sub_active, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 and R10: enable from rest
        cur_req = "R5"; n = cyc;
        main_tgt = 5'd5; main_en = 1'b1;
        plan_ramp(0, 0, 5, n + 1, P0, "R5", last);
        @(negedge clk);
        chk(main_active == 1'b1, "R10", "active after enable", main_active, 1);
        wait_until(last + 2); drain("R5");

        // R1: long climb to full scale
        cur_req = "R1"; n = cyc;
        main_tgt = 5'd31;
        plan_ramp(0, 5, 31, n + 1, P0, "R1", last);
        wait_until(last + 2); drain("R1");

        // R3: full-scale fade at the slowest rate
        cur_req = "R3"; n = cyc;
        rate = 2'b11; main_tgt = 5'd0;
        plan_ramp(0, 31, 0, n + 1, P3, "R3", last);
        wait_until(n + 1 + 29 * P3 + (P3 - 1));
        chk(main_code == 1, "R3", "code one cycle before end", main_code, 1);
        wait_until(n + 1 + 30 * P3);
        chk(main_code == 0, "R3", "code at 30 periods", main_code, 0);
        wait_until(last + 2); drain("R3");

        // R2: the two middle rate settings
        cur_req = "R2"; n = cyc;
        rate = 2'b10; main_tgt = 5'd3;
        plan_ramp(0, 0, 3, n + 1, P2, "R2", last);
        wait_until(last + 2); drain("R2");
        n = cyc;
        rate = 2'b01; main_tgt = 5'd0;
        plan_ramp(0, 3, 0, n + 1, P1, "R2", last);
        wait_until(last + 2); drain("R2");

        // R7: target written mid-ramp is deferred
        cur_req = "R7"; n = cyc;
        rate = 2'b00; main_tgt = 5'd6;
        plan_ramp(0, 0, 6, n + 1, P0, "R7", last);
        wait_until(n + 4);
        main_tgt = 5'd1;
        plan_ramp(0, 6, 1, last + 1, P0, "R7", last2);
        wait_until(last2 + 2); drain("R7");

        // R6: enable dropped mid-ramp
        cur_req = "R6"; n = cyc;
        main_tgt = 5'd10;
        plan_ramp(0, 1, 4, n + 1, P0, "R6", last);
        wait_until(n + 8);
        main_en = 1'b0;
        plan_ramp(0, 4, 0, n + 7 + P0, P0, "R6", last2);
        wait_until(last2 - 1);
        chk(main_active == 1'b1, "R10", "active while fading", main_active, 1);
        wait_until(last2);
        chk(main_active == 1'b0, "R10", "inactive at zero", main_active, 0);
        wait_until(last2 + 2); drain("R6");

        // R12: independent secondary channel
        cur_req = "R12"; n = cyc;
        sub_tgt = 5'd4; sub_en = 1'b1; main_tgt = 5'd7;
        plan_ramp(1, 0, 4, n + 1, P0, "R12", last);
        wait_until(last + 2); drain("R12");
        chk(main_code == 0, "R12", "main untouched", main_code, 0);

        // R8: unison mode
        cur_req = "R8"; n = cyc;
        unison = 1'b1; main_tgt = 5'd2; main_en = 1'b1; sub_en = 1'b0; sub_tgt = 5'd9;
        plan_ramp(0, 0, 2, n + 1, P0, "R8", last);
        plan_ramp(1, 4, 2, n + 1, P0, "R8", last);
        wait_until(last + 2); drain("R8");
        sub_tgt = 5'd20; sub_en = 1'b1;
        wait_until(cyc + 10); drain("R8");
        chk(sub_code == 2, "R8", "sub ignores own target", sub_code, 2);
        n = cyc;
        main_en = 1'b0;
        plan_ramp(0, 2, 0, n + 1, P0, "R8", last);
        plan_ramp(1, 2, 0, n + 1, P0, "R8", last);
        wait_until(last + 2); drain("R8");
        chk(sub_active == 1'b0, "R8", "sub follows main enable", sub_active, 0);

        // R9: feedback mode
        cur_req = "R9"; n = cyc;
        unison = 1'b0; sub_tgt = 5'd3; sub_en = 1'b1;
        plan_ramp(1, 0, 3, n + 1, P0, "R9", last);
        wait_until(last + 2); drain("R9");
        n = cyc;
        oled = 1'b1; main_tgt = 5'd2; main_en = 1'b1;
        push(1, 0, n + 1, "R9");
        plan_ramp(0, 0, 2, n + 1, P0, "R9", last);
        @(negedge clk);
        chk(sub_active == 1'b0, "R9", "sub inactive in feedback mode", sub_active, 0);
        sub_tgt = 5'd5;
        wait_until(last + 6); drain("R9");
        chk(sub_code == 0, "R9", "sub held at zero", sub_code, 0);
        n = cyc;
        oled = 1'b0;
        plan_ramp(1, 0, 5, n + 1, P0, "R9", last);
        wait_until(last + 2); drain("R9");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule